// File: doc/BRIEF.md
# Timed Instruction Injection Sequencer

This block sits between a stream of 64-bit injection tokens and the fetch side of a core under test. Each token carries a command byte, a 16-bit timestamp and a 32-bit instruction word. Tokens enter through a valid/ready input, one at a time. An instruction token is held back for a number of cycles and then presented on an issue port. That number is the difference between its timestamp and the timestamp of the token before it. A token with a nonzero command byte does not issue anything. It produces a one-cycle command pulse, for example to reset the device under test.

Each issued word also carries a flag that tells whether the low half is a 16-bit compressed encoding. A bypass input drops the timing altogether, for consumers that do not need repeatable delays. The block decodes nothing beyond the fields listed here.

Top module: `inject_sequencer`

## Requirements
- R1: Token fields: the command byte is bits 55..48, the timestamp is bits 47..32, the instruction word is bits 31..0; bits 63..56 have no effect on any output.
- R2: A token whose command byte is nonzero raises `cmd_pulse_o` for exactly the one cycle after the accepting edge, with `cmd_code_o` equal to that byte, and never raises `issue_valid_o`; `tok_ready_o` stays high.
- R3: For an instruction token (command byte zero) accepted at edge E, the delay is d = (timestamp - previous timestamp) mod 2^16; `issue_valid_o` rises at edge E + d, and at edge E + 0 (the cycle right after acceptance) when d is 0.
- R4: The subtraction in R3 wraps: previous timestamp 0xFFFE followed by timestamp 0x0002 gives a delay of 4.
- R5: After reset the previous timestamp is 0.
- R6: Every accepted token, command or instruction, makes its own timestamp the previous timestamp for the next token.
- R7: When `bypass_i` is high at the accepting edge of an instruction token, `issue_valid_o` rises at that edge regardless of the timestamp; the timestamp still becomes the previous timestamp.
- R8: `tok_ready_o` is low from the accepting edge of an instruction token until the edge at which the issued word is taken, and high at all other times.
- R9: Once `issue_valid_o` is high it stays high with `issue_word_o` unchanged until a cycle with `issue_ready_i` high; at the following edge it falls.
- R10: `issue_short_o` is high with the issued word exactly when bits 1..0 of that word are not both 1.
- R11: In reset `tok_ready_o` is high and `issue_valid_o` and `cmd_pulse_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid_i | input | 1 | Token present |
| tok_ready_o | output | 1 | Token can be taken this cycle |
| tok_data_i | input | 64 | Injection token |
| bypass_i | input | 1 | Ignore timestamps and issue at once |
| issue_valid_o | output | 1 | Instruction word presented |
| issue_ready_i | input | 1 | Consumer takes the instruction word |
| issue_word_o | output | 32 | Instruction word |
| issue_short_o | output | 1 | Word is a 16-bit compressed encoding |
| cmd_pulse_o | output | 1 | One-cycle trace command strobe |
| cmd_code_o | output | 8 | Command byte belonging to the strobe |

## Verification
Every result is tied to one accepting edge. The command pulse is due in the cycle right after that edge. The issued word is due d edges after acceptance, or at acceptance itself when d is 0 or the bypass is set, and it then stays up for as long as the consumer stalls. The bench drives and samples only on falling edges and counts those edges after acceptance. It requires the first high `issue_valid_o` on falling edge d+1 and a low `tok_ready_o` on every falling edge before it. After release it requires `tok_ready_o` back high on the first falling edge after the word is taken.

// File: rtl/inject_seq_pkg.sv
package inject_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_HOLD = 2'd2
   } sq_state_e;

endpackage

// File: rtl/inject_token_split.sv
module inject_token_split #(
   parameter int TOK_W  = 64,
   parameter int CMD_W  = 8,
   parameter int TS_W   = 16,
   parameter int WORD_W = 32
) (
   input  logic [TOK_W-1:0]  tok_i,
   output logic [CMD_W-1:0]  cmd_o,
   output logic [TS_W-1:0]   ts_o,
   output logic [WORD_W-1:0] word_o,
   output logic              is_cmd_o,
   output logic              is_short_o
);
   localparam int WORD_LO = 0;
   localparam int TS_LO   = WORD_LO + WORD_W;
   localparam int CMD_LO  = TS_LO + TS_W;
   localparam int USED_W  = CMD_LO + CMD_W;

   if (USED_W > TOK_W) begin : g_bad_width
      $error("token too narrow for its fields");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("instruction word needs at least two bits");
   end

   assign word_o     = tok_i[WORD_LO +: WORD_W];
   assign ts_o       = tok_i[TS_LO +: TS_W];
   assign cmd_o      = tok_i[CMD_LO +: CMD_W];
   assign is_cmd_o   = |cmd_o;
   assign is_short_o = (word_o[1:0] != 2'b11);
endmodule

// File: rtl/inject_delay_timer.sv
module inject_delay_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             busy_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("counter width must be positive");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == ONE);

   // R3: a new delay is only started once the previous one has run out
   a_r3_load_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (cnt_q == '0));
   // R3: a loaded nonzero delay counts down by exactly one per cycle
   a_r3_counts_down : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/inject_sequencer.sv
module inject_sequencer
   import inject_seq_pkg::*;
#(
   parameter int TOK_W        = 64,
   parameter int CMD_W        = 8,
   parameter int TS_W         = 16,
   parameter int WORD_W       = 32,
   parameter bit ALLOW_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_valid_i,
   output logic              tok_ready_o,
   input  logic [TOK_W-1:0]  tok_data_i,
   input  logic              bypass_i,
   output logic              issue_valid_o,
   input  logic              issue_ready_i,
   output logic [WORD_W-1:0] issue_word_o,
   output logic              issue_short_o,
   output logic              cmd_pulse_o,
   output logic [CMD_W-1:0]  cmd_code_o
);
   localparam int CMD_LO = WORD_W + TS_W;

   sq_state_e         state_q, state_d;
   logic [CMD_W-1:0]  f_cmd;
   logic [TS_W-1:0]   f_ts;
   logic [WORD_W-1:0] f_word;
   logic              f_is_cmd, f_is_short;
   logic [TS_W-1:0]   prev_ts_q, delta;
   logic              accept, take_insn, skip_wait, timer_load, timer_busy, timer_done;
   logic [WORD_W-1:0] word_q;
   logic              short_q;
   logic              pulse_q;
   logic [CMD_W-1:0]  code_q;

   inject_token_split #(
      .TOK_W(TOK_W), .CMD_W(CMD_W), .TS_W(TS_W), .WORD_W(WORD_W)
   ) u_split (
      .tok_i     (tok_data_i),
      .cmd_o     (f_cmd),
      .ts_o      (f_ts),
      .word_o    (f_word),
      .is_cmd_o  (f_is_cmd),
      .is_short_o(f_is_short)
   );

   assign tok_ready_o = (state_q == SQ_IDLE);
   assign accept      = tok_valid_i & tok_ready_o;
   assign take_insn   = accept & ~f_is_cmd;
   assign delta       = f_ts - prev_ts_q;

   if (ALLOW_BYPASS) begin : g_bypass
      assign skip_wait = bypass_i | (delta == '0);
   end else begin : g_timed_only
      assign skip_wait = (delta == '0);
   end

   assign timer_load = take_insn & ~skip_wait;

   inject_delay_timer #(.CNT_W(TS_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (timer_load),
      .load_val_i(delta),
      .busy_o    (timer_busy),
      .done_o    (timer_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: if (take_insn) state_d = skip_wait ? SQ_HOLD : SQ_WAIT;
         SQ_WAIT: if (timer_done) state_d = SQ_HOLD;
         SQ_HOLD: if (issue_ready_i) state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         prev_ts_q <= '0;
         word_q    <= '0;
         short_q   <= 1'b0;
         pulse_q   <= 1'b0;
         code_q    <= '0;
      end else begin
         state_q <= state_d;
         pulse_q <= accept & f_is_cmd;
         if (accept) prev_ts_q <= f_ts;
         if (take_insn) begin
            word_q  <= f_word;
            short_q <= f_is_short;
         end
         if (accept & f_is_cmd) code_q <= f_cmd;
      end
   end

   assign issue_valid_o = (state_q == SQ_HOLD);
   assign issue_word_o  = word_q;
   assign issue_short_o = short_q;
   assign cmd_pulse_o   = pulse_q;
   assign cmd_code_o    = code_q;

   // R9: a presented word is neither dropped nor changed while stalled
   a_r9_hold_until_taken : assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid_o && !issue_ready_i) |=> (issue_valid_o && $stable(issue_word_o)));
   // R2: a pulse only follows the acceptance of a command token
   a_r2_pulse_from_cmd : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse_o |-> $past(tok_valid_i && tok_ready_o && (tok_data_i[CMD_LO +: CMD_W] != '0)));
   // R2: a command token never starts an issue
   a_r2_cmd_no_issue : assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid_i && tok_ready_o && (tok_data_i[CMD_LO +: CMD_W] != '0)) |=> !issue_valid_o);
   // R8: input is closed while the delay counter runs
   a_r8_closed_in_wait : assert property (@(posedge clk) disable iff (!rst_n)
      timer_busy |-> !tok_ready_o);
   // R7: bypassed instruction is presented on the next cycle
   a_r7_bypass_next : assert property (@(posedge clk) disable iff (!rst_n)
      (ALLOW_BYPASS && tok_valid_i && tok_ready_o && bypass_i
       && (tok_data_i[CMD_LO +: CMD_W] == '0)) |=> issue_valid_o);
endmodule

// File: tb/inject_sequencer_tb.sv
module inject_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tok_valid_i;
   logic        tok_ready_o;
   logic [63:0] tok_data_i;
   logic        bypass_i;
   logic        issue_valid_o;
   logic        issue_ready_i;
   logic [31:0] issue_word_o;
   logic        issue_short_o;
   logic        cmd_pulse_o;
   logic [7:0]  cmd_code_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   logic [15:0] prev_ts = 16'h0;

   always #5 clk = ~clk;

   inject_sequencer dut_i (
      .clk(clk), .rst_n(rst_n),
      .tok_valid_i(tok_valid_i), .tok_ready_o(tok_ready_o), .tok_data_i(tok_data_i),
      .bypass_i(bypass_i),
      .issue_valid_o(issue_valid_o), .issue_ready_i(issue_ready_i),
      .issue_word_o(issue_word_o), .issue_short_o(issue_short_o),
      .cmd_pulse_o(cmd_pulse_o), .cmd_code_o(cmd_code_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_tok(logic [7:0] pad, logic [7:0] cmd, logic [15:0] ts,
                                          logic [31:0] word);
      return {pad, cmd, ts, word};
   endfunction

   function automatic bit exp_short(logic [31:0] w);
      return (w[1:0] != 2'b11);
   endfunction

   // Sends one token and checks every result it is expected to produce.
   task automatic send(input logic [63:0] tok, input bit byp, input int stall, input string tag);
      logic [7:0]  cmd  = tok[55:48];
      logic [15:0] ts   = tok[47:32];
      logic [31:0] word = tok[31:0];
      int d;
      int k;
      @(negedge clk);
      check(tok_ready_o == 1'b1, {tag, " R8 ready before token"}, tok_ready_o, 1);
      tok_valid_i = 1'b1;
      tok_data_i  = tok;
      bypass_i    = byp;
      @(posedge clk);
      @(negedge clk);
      tok_valid_i = 1'b0;
      bypass_i    = 1'b0;
      tok_data_i  = {$urandom, $urandom};
      if (cmd != 8'h0) begin
         // R2 R6: one-cycle pulse, no issue, timestamp recorded
         check(cmd_pulse_o == 1'b1, {tag, " R2 pulse"}, cmd_pulse_o, 1);
         check(cmd_code_o == cmd, {tag, " R2 code"}, cmd_code_o, cmd);
         check(issue_valid_o == 1'b0, {tag, " R2 no issue"}, issue_valid_o, 0);
         check(tok_ready_o == 1'b1, {tag, " R2 ready"}, tok_ready_o, 1);
         prev_ts = ts;
         @(negedge clk);
         check(cmd_pulse_o == 1'b0, {tag, " R2 single cycle"}, cmd_pulse_o, 0);
         check(issue_valid_o == 1'b0, {tag, " R2 no issue later"}, issue_valid_o, 0);
         return;
      end
      d = byp ? 0 : int'(16'(ts - prev_ts));
      prev_ts = ts;
      k = 1;
      while (!issue_valid_o && k <= d + 3) begin
         check(tok_ready_o == 1'b0, {tag, " R8 closed while waiting"}, tok_ready_o, 0);
         @(negedge clk);
         k++;
      end
      // R3 R4 R5 R7: arrival time
      check(k == d + 1, {tag, " R3 delay"}, k - 1, d);
      check(issue_word_o == word, {tag, " R1 word"}, issue_word_o, word);
      check(issue_short_o == exp_short(word), {tag, " R10 short flag"}, issue_short_o,
            exp_short(word));
      for (int s = 0; s < stall; s++) begin
         check(tok_ready_o == 1'b0, {tag, " R8 closed while stalled"}, tok_ready_o, 0);
         @(negedge clk);
         check(issue_valid_o && issue_word_o == word, {tag, " R9 held"}, issue_word_o, word);
      end
      issue_ready_i = 1'b1;
      @(negedge clk);
      issue_ready_i = 1'b0;
      check(issue_valid_o == 1'b0, {tag, " R9 falls after take"}, issue_valid_o, 0);
      check(tok_ready_o == 1'b1, {tag, " R8 reopens"}, tok_ready_o, 1);
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; tok_valid_i = 1'b0; tok_data_i = '0; bypass_i = 1'b0; issue_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      check(tok_ready_o == 1'b1, "R11 ready in reset", tok_ready_o, 1);
      check(issue_valid_o == 1'b0, "R11 valid in reset", issue_valid_o, 0);
      check(cmd_pulse_o == 1'b0, "R11 pulse in reset", cmd_pulse_o, 0);
      rst_n = 1'b1;

      // R5: first token measured from zero; R1 padding ignored
      send(mk_tok(8'hA5, 8'h00, 16'h0003, 32'h0000_0013), 1'b0, 0, "R5 first");
      send(mk_tok(8'hFF, 8'h00, 16'h0003, 32'h1234_5671), 1'b0, 2, "R3 zero delay");
      send(mk_tok(8'h00, 8'h00, 16'hFFFE, 32'h0000_4501), 1'b0, 0, "R4 setup");
      send(mk_tok(8'h3C, 8'h00, 16'h0002, 32'hDEAD_BEEF), 1'b0, 1, "R4 wrap");
      // R6: a command moves the reference point
      send(mk_tok(8'h00, 8'h01, 16'h0100, 32'hFFFF_FFFF), 1'b0, 0, "R6 cmd");
      send(mk_tok(8'h00, 8'h00, 16'h0102, 32'h0000_0002), 1'b0, 0, "R6 after cmd");
      send(mk_tok(8'h00, 8'h7E, 16'h0104, 32'h0), 1'b0, 0, "R2 cmd a");
      send(mk_tok(8'h00, 8'h02, 16'h0105, 32'h0), 1'b0, 0, "R2 cmd b");
      // R7: bypass ignores a large gap, still records timestamp
      send(mk_tok(8'h00, 8'h00, 16'h5000, 32'h0000_0073), 1'b1, 1, "R7 bypass");
      send(mk_tok(8'h00, 8'h00, 16'h5005, 32'h0000_0074), 1'b0, 0, "R7 after bypass");

      for (int i = 0; i < 40; i++) begin
         logic [7:0]  cmd = ($urandom_range(0, 4) == 0) ? 8'($urandom_range(1, 255)) : 8'h00;
         logic [15:0] ts  = prev_ts + 16'($urandom_range(0, 12));
         bit          byp = ($urandom_range(0, 6) == 0);
         send(mk_tok(8'($urandom), cmd, ts, $urandom), byp, $urandom_range(0, 3), "rand");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
         end
      end
   end
endmodule